// File: doc/BRIEF.md
# Trap and Delay-Slot Exception Entry Sequencer

This block sits next to the decode stage of a simple in-order CPU and starts exception entry for two causes. The first is an explicit software trap that carries an 8-bit vector number. The second is a forbidden instruction sitting in the delay slot of a delayed branch. The decode stage does not pass opcodes in. It passes class flags for the instruction, together with configuration inputs that say whether a floating-point unit is fitted and awake, and whether a register bank is fitted.

When either cause is accepted, the block captures its context and holds the decode stage with a busy output. It then performs four steps in a fixed order:
1. Read the handler address from the vector table at VBR + 4 × vector.
2. Push the status word to SP − 4.
3. Push the return address to SP − 8.
4. Send a one-cycle redirect to the fetch unit.

The redirect carries the handler address and the final stack pointer. Memory traffic uses a single word port with a request/acknowledge handshake, and the port may insert any number of wait states.

Top module: `exc_entry_seq`

## Requirements
- R1: A valid decoded trap outside a delay slot starts entry. The first memory access is a read (write-enable 0) at VBR + 4 × trap vector, where the vector is the 8-bit immediate. The word read back becomes the handler address.
- R2: After the vector read, the block writes the status word to SP − 4 and then writes the return address to SP − 8. The redirect pulse follows, and with it the stack-pointer output shows SP − 8. SP, SR and VBR are all sampled at acceptance.
- R3: For a trap, the return address that is pushed is the trap's own address plus 2.
- R4: A valid instruction in a delay slot raises the slot exception if it is undefined, writes the PC, is 32 bits long, restores the register bank, or is a divide. The slot exception uses vector 6 and pushes the address of the preceding delayed branch.
- R5: A floating-point-class instruction in a delay slot raises the slot exception if the floating-point unit is absent or in standby, and is accepted otherwise.
- R6: A register-bank-class instruction in a delay slot raises the slot exception if no register bank is fitted, and is accepted otherwise.
- R7: Outside a delay slot, every class flag is ignored. With no trap, no entry starts and busy stays low.
- R8: A trap in a delay slot counts as a PC-writing instruction. It raises the slot exception with vector 6 and the branch address, not the trap vector.
- R9: Busy rises in the cycle after acceptance and stays high through the redirect cycle. Decode inputs presented while busy is high start nothing.
- R10: Each memory request holds its address, data and direction stable until it is acknowledged, whatever the number of wait states. The redirect is exactly one cycle wide and carries the handler address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | Decoded instruction valid |
| dec_pc_i | input | AW | Address of the decoded instruction |
| dec_is_trap_i | input | 1 | Instruction is a software trap |
| dec_trap_vec_i | input | VEC_W | Trap vector immediate |
| dec_in_slot_i | input | 1 | Instruction sits in a delay slot |
| dec_branch_pc_i | input | AW | Address of the delayed branch owning the slot |
| cls_undef_i | input | 1 | Undefined code |
| cls_pc_write_i | input | 1 | Writes the PC |
| cls_long_i | input | 1 | 32-bit-long instruction |
| cls_bank_restore_i | input | 1 | Register-bank restore |
| cls_divide_i | input | 1 | Signed or unsigned divide |
| cls_fpu_i | input | 1 | Floating-point-related instruction |
| cls_bank_i | input | 1 | Register-bank-related instruction |
| cfg_fpu_present_i | input | 1 | Floating-point unit fitted |
| cfg_fpu_standby_i | input | 1 | Floating-point unit in standby |
| cfg_bank_present_i | input | 1 | Register bank fitted |
| vbr_i | input | AW | Vector base |
| sr_i | input | DW | Status word to save |
| sp_i | input | AW | Stack pointer before entry |
| busy_o | output | 1 | Entry in progress, stall decode |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Write data |
| mem_ack_i | input | 1 | Request accepted this cycle |
| mem_rdata_i | input | DW | Read data, valid with ack |
| redir_valid_o | output | 1 | One-cycle redirect pulse |
| redir_pc_o | output | AW | Handler address |
| sp_o | output | AW | Stack pointer after the two pushes |

## Verification
A trap and the slot check can both apply to one decoded instruction. The bench provokes this by presenting a trap with its slot flag set (R8), and it judges the result by the vector-read address (VBR + 24) and the pushed branch address that the scoreboard expects. A new trap presented during a running entry sequence is the second overlap. The scoreboard flags any memory request it did not queue, and the busy output is then sampled low once the first sequence finishes.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_VEC, ST_PSR, ST_PPC, ST_JMP
  } exc_st_e;

  typedef struct packed {
    logic undef;
    logic pc_write;
    logic long_op;
    logic bank_restore;
    logic divide;
    logic fpu_op;
    logic bank_op;
  } slot_cls_t;
endpackage

// File: rtl/slot_check.sv
module slot_check
  import exc_seq_pkg::*;
#(
  parameter bit STANDBY_IS_ABSENT = 1'b1
) (
  input  slot_cls_t cls_i,
  input  logic      is_trap_i,
  input  logic      fpu_present_i,
  input  logic      fpu_standby_i,
  input  logic      bank_present_i,
  output logic      illegal_o
);
  logic fpu_usable;
  logic fpu_undef, bank_undef, fixed_bad;

  generate
    if (STANDBY_IS_ABSENT) begin : g_sb
      assign fpu_usable = fpu_present_i & ~fpu_standby_i;
    end else begin : g_nosb
      assign fpu_usable = fpu_present_i;
    end
  endgenerate

  // a trap rewrites the PC, so it belongs to the PC-write class
  assign fixed_bad  = cls_i.undef | cls_i.pc_write | is_trap_i | cls_i.long_op
                    | cls_i.bank_restore | cls_i.divide;
  assign fpu_undef  = cls_i.fpu_op & ~fpu_usable;
  assign bank_undef = cls_i.bank_op & ~bank_present_i;
  assign illegal_o  = fixed_bad | fpu_undef | bank_undef;
endmodule

// File: rtl/exc_fsm.sv
module exc_fsm
  import exc_seq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [AW-1:0]    ret_pc_i,
  input  logic [AW-1:0]    vbr_i,
  input  logic [DW-1:0]    sr_i,
  input  logic [AW-1:0]    sp_i,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             redir_valid_o,
  output logic [AW-1:0]    redir_pc_o,
  output logic [AW-1:0]    sp_o
);
  localparam int WORD_B = 4;

  exc_st_e       state_q;
  logic [AW-1:0] vaddr_q, ret_q, sp_q, hnd_q;
  logic [DW-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vaddr_q <= '0;
      ret_q   <= '0;
      sp_q    <= '0;
      sr_q    <= '0;
      hnd_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_VEC;
          vaddr_q <= vbr_i + AW'({vec_i, 2'b00});
          ret_q   <= ret_pc_i;
          sp_q    <= sp_i;
          sr_q    <= sr_i;
        end
        ST_VEC: if (mem_ack_i) begin
          hnd_q   <= AW'(mem_rdata_i);
          state_q <= ST_PSR;
        end
        ST_PSR: if (mem_ack_i) state_q <= ST_PPC;
        ST_PPC: if (mem_ack_i) state_q <= ST_JMP;
        ST_JMP:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (state_q)
      ST_VEC: begin
        mem_req_o  = 1'b1;
        mem_addr_o = vaddr_q;
      end
      ST_PSR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_q - AW'(WORD_B);
        mem_wdata_o = sr_q;
      end
      ST_PPC: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_q - AW'(2 * WORD_B);
        mem_wdata_o = DW'(ret_q);
      end
      default: ;
    endcase
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign redir_valid_o = (state_q == ST_JMP);
  assign redir_pc_o    = hnd_q;
  assign sp_o          = sp_q - AW'(2 * WORD_B);

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o)));
  a_r10_redir_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_valid_o |=> !redir_valid_o);
  a_r2_redir_after_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_valid_o |-> ($past(mem_ack_i) && $past(mem_we_o)));
  a_r9_busy_on_redir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_valid_o |-> busy_o);
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !redir_valid_o));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int VEC_W    = 8,
  parameter int SLOT_VEC = 6,
  parameter int ILEN_B   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dec_valid_i,
  input  logic [AW-1:0]    dec_pc_i,
  input  logic             dec_is_trap_i,
  input  logic [VEC_W-1:0] dec_trap_vec_i,
  input  logic             dec_in_slot_i,
  input  logic [AW-1:0]    dec_branch_pc_i,
  input  logic             cls_undef_i,
  input  logic             cls_pc_write_i,
  input  logic             cls_long_i,
  input  logic             cls_bank_restore_i,
  input  logic             cls_divide_i,
  input  logic             cls_fpu_i,
  input  logic             cls_bank_i,
  input  logic             cfg_fpu_present_i,
  input  logic             cfg_fpu_standby_i,
  input  logic             cfg_bank_present_i,
  input  logic [AW-1:0]    vbr_i,
  input  logic [DW-1:0]    sr_i,
  input  logic [AW-1:0]    sp_i,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             redir_valid_o,
  output logic [AW-1:0]    redir_pc_o,
  output logic [AW-1:0]    sp_o
);
  slot_cls_t        cls;
  logic             slot_bad, slot_exc, trap_exc, accept;
  logic [VEC_W-1:0] sel_vec;
  logic [AW-1:0]    sel_ret;

  assign cls = '{undef: cls_undef_i, pc_write: cls_pc_write_i, long_op: cls_long_i,
                 bank_restore: cls_bank_restore_i, divide: cls_divide_i,
                 fpu_op: cls_fpu_i, bank_op: cls_bank_i};

  slot_check #(.STANDBY_IS_ABSENT(1'b1)) u_chk (
    .cls_i          (cls),
    .is_trap_i      (dec_is_trap_i),
    .fpu_present_i  (cfg_fpu_present_i),
    .fpu_standby_i  (cfg_fpu_standby_i),
    .bank_present_i (cfg_bank_present_i),
    .illegal_o      (slot_bad)
  );

  assign slot_exc = dec_in_slot_i & slot_bad;
  assign trap_exc = dec_is_trap_i & ~dec_in_slot_i;
  assign accept   = dec_valid_i & ~busy_o & (slot_exc | trap_exc);
  assign sel_vec  = slot_exc ? VEC_W'(SLOT_VEC) : dec_trap_vec_i;
  assign sel_ret  = slot_exc ? dec_branch_pc_i : dec_pc_i + AW'(ILEN_B);

  exc_fsm #(.AW(AW), .DW(DW), .VEC_W(VEC_W)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (accept),
    .vec_i         (sel_vec),
    .ret_pc_i      (sel_ret),
    .vbr_i         (vbr_i),
    .sr_i          (sr_i),
    .sp_i          (sp_i),
    .busy_o        (busy_o),
    .mem_req_o     (mem_req_o),
    .mem_we_o      (mem_we_o),
    .mem_addr_o    (mem_addr_o),
    .mem_wdata_o   (mem_wdata_o),
    .mem_ack_i     (mem_ack_i),
    .mem_rdata_i   (mem_rdata_i),
    .redir_valid_o (redir_valid_o),
    .redir_pc_o    (redir_pc_o),
    .sp_o          (sp_o)
  );

  a_r8_trap_in_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && !busy_o && dec_in_slot_i && dec_is_trap_i)
      |=> (mem_req_o && !mem_we_o && mem_addr_o == $past(vbr_i) + AW'(4 * SLOT_VEC)));
  a_r9_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && !busy_o && dec_is_trap_i) |=> busy_o);
  a_r7_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(dec_valid_i && (dec_is_trap_i || dec_in_slot_i))) |=> !busy_o);
endmodule

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;
  typedef struct {
    int          kind;   // 0 read, 1 write, 2 redirect
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } item_t;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic dec_valid = 0, dec_trap = 0, dec_slot = 0;
  logic [31:0] dec_pc = 0, dec_bpc = 0, vbr = 0, sr = 0, sp = 0;
  logic [7:0] dec_vec = 0;
  logic [6:0] cls = 0; // [6]undef [5]pc_write [4]long [3]bank_restore [2]divide [1]fpu [0]bank
  logic fpu_p = 1, fpu_sb = 0, bank_p = 1;
  logic busy, req, we, redir, ack = 0;
  logic [31:0] addr, wdata, rdata = 0, rpc, spo;

  int checks = 0, errors = 0, waits = 0, wcnt = 0, seed = 1;
  bit done = 0;
  item_t q[$];

  exc_entry_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .dec_valid_i(dec_valid), .dec_pc_i(dec_pc),
    .dec_is_trap_i(dec_trap), .dec_trap_vec_i(dec_vec), .dec_in_slot_i(dec_slot),
    .dec_branch_pc_i(dec_bpc), .cls_undef_i(cls[6]), .cls_pc_write_i(cls[5]),
    .cls_long_i(cls[4]), .cls_bank_restore_i(cls[3]), .cls_divide_i(cls[2]),
    .cls_fpu_i(cls[1]), .cls_bank_i(cls[0]), .cfg_fpu_present_i(fpu_p),
    .cfg_fpu_standby_i(fpu_sb), .cfg_bank_present_i(bank_p), .vbr_i(vbr), .sr_i(sr),
    .sp_i(sp), .busy_o(busy), .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .mem_ack_i(ack), .mem_rdata_i(rdata),
    .redir_valid_o(redir), .redir_pc_o(rpc), .sp_o(spo)
  );

  function automatic logic [31:0] handler_of(logic [31:0] a);
    return 32'h0C00_0000 | {a[23:0], 4'h0} & 32'h0FFF_FFFE;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(int kind, logic [31:0] a, logic [31:0] d);
    item_t e;
    if (q.size() == 0) begin
      checks++; errors++;
      $display("FAIL R9 actual=unexpected kind %0d addr %h expected=no traffic", kind, a);
      return;
    end
    e = q.pop_front();
    check({e.tag, " kind"}, kind, e.kind);
    check({e.tag, " addr"}, a, e.addr);
    check({e.tag, " data"}, d, e.data);
  endtask

  // memory model + monitor
  always @(negedge clk) begin
    if (ack) ack = 0;
    else if (req) begin
      if (wcnt < waits) wcnt++;
      else begin
        wcnt = 0;
        compare(we ? 1 : 0, addr, we ? wdata : handler_of(addr));
        rdata = handler_of(addr);
        ack = 1;
      end
    end
    if (redir) compare(2, rpc, spo);
  end

  task automatic issue(logic [31:0] pc, logic [31:0] bpc, logic trap, logic slot,
                       logic [7:0] vec, logic [6:0] c, bit exp_exc, string tag,
                       bit poke_busy = 0);
    logic [31:0] va, ret;
    seed++;
    vbr = 32'h0040_0000 + (seed << 8);
    sp  = 32'h0010_1000 - (seed << 4);
    sr  = 32'h0000_00F0 ^ seed;
    if (exp_exc) begin
      va  = vbr + {22'd0, (slot ? 8'd6 : vec), 2'b00};
      ret = slot ? bpc : pc + 2;
      q.push_back('{0, va, handler_of(va), {tag, " vector read (R1)"}});
      q.push_back('{1, sp - 4, sr, {tag, " SR push (R2)"}});
      q.push_back('{1, sp - 8, ret, {tag, " PC push (R3/R4)"}});
      q.push_back('{2, handler_of(va), sp - 8, {tag, " redirect (R10/R2)"}});
    end
    @(negedge clk);
    dec_valid = 1; dec_pc = pc; dec_bpc = bpc; dec_trap = trap;
    dec_slot = slot; dec_vec = vec; cls = c;
    @(negedge clk);
    dec_valid = 0; cls = 0; dec_trap = 0; dec_slot = 0;
    check({tag, " busy after accept (R9)"}, busy, exp_exc);
    if (poke_busy) begin // R9: trap offered while busy
      dec_valid = 1; dec_trap = 1; dec_vec = 8'h33; dec_pc = 32'h7000;
      @(negedge clk); @(negedge clk);
      dec_valid = 0; dec_trap = 0;
    end
    while (busy || q.size() != 0) @(negedge clk);
    @(negedge clk);
    check({tag, " idle after"}, busy, 0);
    check({tag, " queue drained"}, q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset busy", busy, 0);
    check("R10 reset req", req, 0);
    check("R10 reset redirect", redir, 0);
    rst_n = 1;
    @(negedge clk);
    // R1 R3: plain traps, different vectors and wait states
    waits = 0; issue(32'h1000, 0, 1, 0, 8'h21, 0, 1, "R1 trap v21");
    waits = 3; issue(32'h1F00, 0, 1, 0, 8'hFF, 0, 1, "R1 trap vFF");
    waits = 1; issue(32'h0002, 0, 1, 0, 8'h00, 0, 1, "R3 trap v00");
    // R4: each fixed class in a slot
    for (int b = 2; b <= 6; b++) begin
      waits = b % 3;
      issue(32'h2002 + b * 16, 32'h2000 + b * 16, 0, 1, 8'h00, 7'(1 << b), 1, "R4 slot class");
    end
    // R5
    waits = 0;
    fpu_p = 1; fpu_sb = 0; issue(32'h3002, 32'h3000, 0, 1, 0, 7'b0000010, 0, "R5 fpu usable");
    fpu_p = 1; fpu_sb = 1; issue(32'h3102, 32'h3100, 0, 1, 0, 7'b0000010, 1, "R5 fpu standby");
    fpu_p = 0; fpu_sb = 0; issue(32'h3202, 32'h3200, 0, 1, 0, 7'b0000010, 1, "R5 fpu absent");
    fpu_p = 1;
    // R6
    bank_p = 1; issue(32'h4002, 32'h4000, 0, 1, 0, 7'b0000001, 0, "R6 bank present");
    bank_p = 0; issue(32'h4102, 32'h4100, 0, 1, 0, 7'b0000001, 1, "R6 bank absent");
    // R7: flags outside a slot ignored, benign slot instruction accepted
    issue(32'h5000, 0, 0, 0, 0, 7'b1111111, 0, "R7 flags outside slot");
    bank_p = 1;
    issue(32'h5102, 32'h5100, 0, 1, 0, 7'b0000000, 0, "R7 clean slot");
    // R8: trap in a slot
    waits = 2; issue(32'h6002, 32'h6000, 1, 1, 8'h44, 0, 1, "R8 trap in slot");
    // R9: decode activity while busy
    waits = 2; issue(32'h6802, 0, 1, 0, 8'h12, 0, 1, "R9 busy ignore", 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule